// File: doc/BRIEF.md
# Sigma-Delta Converter Loop Controller

This block is the digital side of a first-order sigma-delta converter whose integrator is an external RC network. A divider built from the system clock produces a sample tick. On each tick the block takes one captured copy of a comparator bit that reports whether the integrator node is above or below its trip point. It then drives a one-bit feedback line to the opposite level. Through a resistor, that line pushes the integrator back toward its trip point.

The feedback loop runs on every tick, whether or not a measurement is in progress. This keeps the integrator settled at its operating point, so a measurement can begin at any time.

A measurement is a window of N ticks. A start request loads N and zeroes the result. While the window is open, each tick whose captured comparator bit is low adds one to the result. When the window is used up, the block closes it and raises a done flag. The done flag and the result hold until the next accepted start. A longer window gives a finer result.

Top module: `dsm_loop_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, `fb_out` is 0, `result` is 0 and `done` is 0.
- R2: `sample_tick` is a single-cycle pulse. Its period is TICK_DIV clocks, where TICK_DIV = CLK_HZ/1_000_000*TICK_US (8 in the bench configuration).
- R3: `cmp_in` passes through a two-flop synchroniser and is captured once per tick. `fb_out` takes the complement of the captured bit: 1 when it is low and 0 when it is high.
- R4: `fb_out` changes only at the second rising edge after the edge on which `sample_tick` is sampled high. This delay is the same for a high and a low comparator bit.
- R5: Feedback tracking continues on every tick, both while no measurement runs and after `done` has risen.
- R6: A `start` pulse while idle clears `done`, sets `result` to 0 and loads the CNT_W-bit (16-bit by default) window length from `n_ticks`. The final `result` equals the number of the next `n_ticks` ticks whose captured bit was 0.
- R7: `done` rises on the tick that ends the window, and the measurement stops counting on that tick. Later ticks leave `result` and `done` unchanged until the next accepted start.
- R8: A `start` pulse while a measurement is running is ignored. The window length and the count are unchanged.
- R9: A start with `n_ticks` = 0 finishes on the first following tick, with `done` = 1 and `result` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_in | input | 1 | Asynchronous comparator bit from the integrator node |
| start | input | 1 | Measurement request, one-cycle pulse |
| n_ticks | input | CNT_W | Window length in ticks, sampled on an accepted start |
| fb_out | output | 1 | One-bit feedback drive to the integrator resistor |
| sample_tick | output | 1 | Single-cycle sample tick pulse |
| result | output | CNT_W | Count of low samples in the window |
| done | output | 1 | Window complete; held until the next accepted start |

## Verification
A fault in the synchroniser, the snapshot register or the feedback stage shows at `fb_out` within two clocks of a tick. It appears either as a wrong level or as a change on the wrong edge. A fault in the low counter or the window counter is mostly hidden until the window closes. It then shows as a wrong `result` or as `done` rising a tick early or late, up to N ticks after the start. For that reason the bench sweeps every window length from 0 to 20 under four comparator patterns, and checks that `done` stays low on every tick before the last.

// File: rtl/dsm_loop_pkg.sv
package dsm_loop_pkg;

  // Clocks per sample tick for a given clock rate and tick period in microseconds.
  function automatic int unsigned tick_div(input int unsigned clk_hz,
                                           input int unsigned tick_us);
    return (clk_hz / 1_000_000) * tick_us;
  endfunction

endpackage

// File: rtl/dsm_tick_gen.sv
module dsm_tick_gen #(
  parameter int unsigned DIV = 25000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q == CW'(DIV - 1)) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/dsm_cmp_track.sv
module dsm_cmp_track #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic cmp_in,
  output logic cmp_sync,
  output logic snap_valid,
  output logic snap,
  output logic fb_out
);
  logic [SYNC_STAGES-1:0] sync_q;

  // Synchroniser chain: stage 0 samples the pin, the last stage feeds the snapshot.
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b0;
          else     sync_q[0] <= cmp_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign cmp_sync = sync_q[SYNC_STAGES-1];

  // Stage 1: one capture per tick. Stage 2: feedback update, same depth for both levels.
  always_ff @(posedge clk) begin
    if (rst) begin
      snap       <= 1'b0;
      snap_valid <= 1'b0;
      fb_out     <= 1'b0;
    end else begin
      snap_valid <= tick;
      if (tick)       snap   <= cmp_sync;
      if (snap_valid) fb_out <= ~snap;
    end
  end
endmodule

// File: rtl/dsm_conv_window.sv
module dsm_conv_window #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             low_in,
  input  logic             start,
  input  logic [CNT_W-1:0] n_ticks,
  output logic [CNT_W-1:0] low_cnt,
  output logic             done,
  output logic             conv_en
);
  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt  <= '0;
      remain_q <= '0;
      conv_en  <= 1'b0;
      done     <= 1'b0;
    end else if (start && !conv_en) begin
      low_cnt  <= '0;
      remain_q <= n_ticks;
      conv_en  <= 1'b1;
      done     <= 1'b0;
    end else if (step && conv_en) begin
      if (remain_q == '0) begin
        conv_en <= 1'b0;
        done    <= 1'b1;
      end else begin
        if (low_in) low_cnt <= low_cnt + 1'b1;
        remain_q <= remain_q - 1'b1;
        if (remain_q == CNT_W'(1)) begin
          conv_en <= 1'b0;
          done    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dsm_loop_ctrl.sv
module dsm_loop_ctrl #(
  parameter int unsigned CLK_HZ  = 250_000_000,
  parameter int unsigned TICK_US = 100,
  parameter int unsigned CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_in,
  input  logic             start,
  input  logic [CNT_W-1:0] n_ticks,
  output logic             fb_out,
  output logic             sample_tick,
  output logic [CNT_W-1:0] result,
  output logic             done
);
  import dsm_loop_pkg::*;

  localparam int unsigned TICK_DIV = tick_div(CLK_HZ, TICK_US);

  logic cmp_sync;
  logic tick_d;
  logic snap;
  logic conv_en;

  dsm_tick_gen #(.DIV(TICK_DIV)) tick_i (
    .clk  (clk),
    .rst  (rst),
    .tick (sample_tick)
  );

  dsm_cmp_track #(.SYNC_STAGES(2)) track_i (
    .clk        (clk),
    .rst        (rst),
    .tick       (sample_tick),
    .cmp_in     (cmp_in),
    .cmp_sync   (cmp_sync),
    .snap_valid (tick_d),
    .snap       (snap),
    .fb_out     (fb_out)
  );

  dsm_conv_window #(.CNT_W(CNT_W)) win_i (
    .clk     (clk),
    .rst     (rst),
    .step    (tick_d),
    .low_in  (~snap),
    .start   (start),
    .n_ticks (n_ticks),
    .low_cnt (result),
    .done    (done),
    .conv_en (conv_en)
  );
endmodule

// File: rtl/dsm_loop_ctrl_chk.sv
module dsm_loop_ctrl_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             sample_tick,
  input logic             fb_out,
  input logic             cmp_sync,
  input logic             tick_d,
  input logic             conv_en,
  input logic             start,
  input logic             done,
  input logic [CNT_W-1:0] result
);
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    sample_tick |=> !sample_tick);

  a_r3_fb_complement: assert property (@(posedge clk) disable iff (rst)
    sample_tick |-> ##2 (fb_out == !$past(cmp_sync, 2)));

  a_r4_fb_only_after_tick: assert property (@(posedge clk) disable iff (rst)
    !$stable(fb_out) |-> $past(sample_tick, 2));

  a_r7_done_stops_window: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> !conv_en);

  a_r7_result_held: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(result)));

  a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (conv_en && start && !tick_d) |=> (conv_en && $stable(result)));
endmodule

bind dsm_loop_ctrl dsm_loop_ctrl_chk #(.CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .sample_tick (sample_tick),
  .fb_out      (fb_out),
  .cmp_sync    (cmp_sync),
  .tick_d      (tick_d),
  .conv_en     (conv_en),
  .start       (start),
  .done        (done),
  .result      (result)
);

// File: tb/dsm_loop_ctrl_tb_top.sv
module dsm_loop_ctrl_tb_top;
  localparam int CNT_W = 16;
  localparam int DIV   = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cmp_in = 1'b0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] n_ticks = '0;
  logic             fb_out;
  logic             sample_tick;
  logic [CNT_W-1:0] result;
  logic             done;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dsm_loop_ctrl #(.CLK_HZ(2_000_000), .TICK_US(4), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .cmp_in(cmp_in), .start(start), .n_ticks(n_ticks),
    .fb_out(fb_out), .sample_tick(sample_tick), .result(result), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive a comparator level, wait for the tick that captures it, check feedback timing.
  task automatic do_tick(input bit v);
    logic prev;
    @(negedge clk);
    cmp_in = v;
    prev = fb_out;
    while (!sample_tick) @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk(fb_out == prev, "R4 fb held one edge after tick", fb_out, prev);
    @(posedge clk); @(negedge clk);
    chk(fb_out == !v, "R3 fb complement of captured bit", fb_out, !v);
  endtask

  function automatic bit pat(input int p, input int i);
    case (p)
      0: return 1'b0;
      1: return 1'b1;
      2: return i[0];
      default: return ((i * 7 + 3) % 5) < 2;
    endcase
  endfunction

  task automatic pulse_start(input int n);
    @(negedge clk);
    start = 1'b1;
    n_ticks = CNT_W'(n);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_conv(input int n, input int p);
    int exp_cnt = 0;
    pulse_start(n);
    chk(done == 1'b0, "R6 start clears done", done, 0);
    chk(result == '0, "R6 start zeroes result", result, 0);
    for (int i = 0; i < ((n == 0) ? 1 : n); i++) begin
      bit v = pat(p, i);
      do_tick(v);
      if (i < n && !v) exp_cnt++;
      if (i < n - 1)
        chk(done == 1'b0, "R7 done low before window end", done, 0);
    end
    if (n == 0) begin
      chk(done == 1'b1, "R9 zero window done", done, 1);
      chk(result == '0, "R9 zero window result", result, 0);
    end else begin
      chk(done == 1'b1, "R7 done at window end", done, 1);
      chk(result == CNT_W'(exp_cnt), "R6 low count", result, exp_cnt);
    end
    for (int i = 0; i < 2; i++) begin
      do_tick(pat(p, i + 1) ^ 1'b1);  // R5 tracking continues after done
      chk(done == 1'b1, "R7 done held", done, 1);
      chk(result == CNT_W'(exp_cnt), "R7 result held", result, exp_cnt);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int gap;
    repeat (3) @(negedge clk);
    chk(fb_out == 1'b0 && result == '0 && done == 1'b0, "R1 reset state",
        {fb_out, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(fb_out == 1'b0 && result == '0 && done == 1'b0, "R1 state after reset",
        {fb_out, done}, 0);

    // R5: tracking while idle, both levels
    do_tick(1'b0); do_tick(1'b1); do_tick(1'b1); do_tick(1'b0);
    chk(done == 1'b0, "R5 idle leaves done low", done, 0);

    // R2: tick period
    while (!sample_tick) @(negedge clk);
    gap = 0;
    @(negedge clk);
    while (!sample_tick) begin gap++; @(negedge clk); end
    chk(gap + 1 == DIV, "R2 tick period", gap + 1, DIV);

    // R6/R7/R9 sweep
    for (int p = 0; p < 4; p++)
      for (int n = 0; n <= 20; n++)
        run_conv(n, p);

    // R8: start during a running window is ignored
    pulse_start(10);
    for (int i = 0; i < 3; i++) do_tick(1'b0);
    pulse_start(2);
    for (int i = 3; i < 10; i++) begin
      do_tick(1'b0);
      if (i < 9) chk(done == 1'b0, "R8 second start ignored", done, 0);
    end
    chk(done == 1'b1, "R8 original window completes", done, 1);
    chk(result == CNT_W'(10), "R8 count unaffected", result, 10);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule